// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Front End

This block is the digital front end of a two-channel 12-bit voltage DAC. A host drives three lines: an active-low select, a serial clock and a data line. The block collects 16-bit command words from this stream, most significant bit first, with bits taken on falling serial-clock edges. Each word is decoded into a write to channel A, to channel B, or to a shared holding register. The same word also carries a speed bit and a power-down bit. The block drives two registered 12-bit output codes and the two mode flags to the analog section.

The holding register lets a host stage a value for channel B and then load it on the same clock as a new channel A value, so both outputs move together. The serial lines are treated as asynchronous. They pass through synchronizers and are oversampled by the system clock. Edges on the serial clock are detected in the system clock domain.

Top module: `dual_dac_serial_if`

## Requirements
- R1: After synchronous reset, both output codes are 0, the speed flag is 0 (slow) and the power-down flag is 0 (normal operation). The holding register is also 0.
- R2: A full command word has 16 bits, received MSB first. Bits 15 and 12 form the two-bit target select {bit15, bit12}. Bit 14 is the speed bit, bit 13 is the power-down bit, and bits 11..0 are the data value.
- R3: Target select 00 writes the data value to channel B and to the holding register.
- R4: Target select 01 writes the data value to the holding register only. Both output codes stay unchanged.
- R5: Target select 10 writes the data value to channel A and copies the holding register to channel B. Both outputs change in the same system clock cycle.
- R6: Target select 11 changes no output code and does not change the holding register.
- R7: Every committed word copies its speed bit to `fast_mode` (1 = fast) and its power-down bit to `power_down` (1 = powered down), whatever its target select.
- R8: A 16-bit word takes effect only after the serial-clock rising edge that follows the 16th falling edge. It does not take effect at the 16th falling edge itself, and it takes effect while the select line is still low.
- R9: A word sent as two 8-bit bursts within one select assertion, with the serial clock idle between the bursts, has the same effect as one continuous 16-bit burst.
- R10: If the select line rises after 1 to 15 bits, the bits received so far are committed right-aligned, with the upper bits zero.
- R11: If the select line rises before any bit has been received, nothing is committed.
- R12: Bits after the 16th within one select assertion are ignored. Only the first 16 bits take effect.
- R13: Serial clock and data activity while the select line is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| ser_cs_n | input | 1 | Active-low frame select |
| ser_clk | input | 1 | Serial clock; data is taken on its falling edges |
| ser_data | input | 1 | Serial data, MSB first |
| code_a | output | 12 | Channel A output code |
| code_b | output | 12 | Channel B output code |
| fast_mode | output | 1 | 1 = fast settling mode, 0 = slow |
| power_down | output | 1 | 1 = power-down requested |

## Verification
The assertions assume that each serial-line level is held for several system clocks, so that every synchronized edge is seen exactly once. They also assume that the data line is stable around each falling serial-clock edge, and that the select line never moves in the same synchronized cycle as a serial-clock edge. The stimulus holds every level for six system clocks and changes data only together with the rising serial-clock edge. It moves the select line only while the serial clock rests high, and it separates every select transition from the nearest clock edge by at least six cycles.

// File: rtl/dual_dac_if_pkg.sv
package dual_dac_if_pkg;

  // Two-bit target select taken from {word[15], word[12]}
  typedef enum logic [1:0] {
    TGT_B_AND_HOLD = 2'b00,
    TGT_HOLD_ONLY  = 2'b01,
    TGT_A_AND_XFER = 2'b10,
    TGT_NONE       = 2'b11
  } tgt_sel_e;

endpackage

// File: rtl/dac_line_sync.sv
module dac_line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dac_frame_shifter.sv
module dac_frame_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               sdi,
  output logic               commit,
  output logic [FRAME_W-1:0] word
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic               sclk_d, cs_d, done;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] shreg;
  logic               sclk_fall, sclk_rise;

  assign sclk_fall = sclk_d & ~sclk;
  assign sclk_rise = ~sclk_d & sclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b1;
      cs_d   <= 1'b1;
      shreg  <= '0;
      cnt    <= '0;
      done   <= 1'b0;
      commit <= 1'b0;
      word   <= '0;
    end else begin
      sclk_d <= sclk;
      cs_d   <= cs_n;
      commit <= 1'b0;
      if (cs_n) begin
        // early termination: commit partial content if anything arrived
        if (!cs_d && cnt != '0 && !done) begin
          commit <= 1'b1;
          word   <= shreg;
        end
        shreg <= '0;
        cnt   <= '0;
        done  <= 1'b0;
      end else begin
        if (sclk_fall && cnt != FULL) begin
          shreg <= {shreg[FRAME_W-2:0], sdi};
          cnt   <= cnt + CNT_W'(1);
        end
        if (sclk_rise && cnt == FULL && !done) begin
          commit <= 1'b1;
          word   <= shreg;
          done   <= 1'b1;
        end
      end
    end
  end

  // R12: once full, further falling edges leave the shift register alone
  assert_extra_bits_ignored_R12: assert property (@(posedge clk) disable iff (rst)
    (cnt == FULL && !cs_n) |=> $stable(shreg));

  // R8: one commit per frame, never on two adjacent cycles
  assert_single_commit_R8: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);

  // R13: a select line that stays high never commits
  assert_idle_no_commit_R13: assert property (@(posedge clk) disable iff (rst)
    (cs_n && cs_d) |=> !commit);

  // R11: a rise with nothing shifted commits nothing
  assert_empty_frame_R11: assert property (@(posedge clk) disable iff (rst)
    (cs_n && !cs_d && cnt == '0) |=> !commit);
endmodule

// File: rtl/dac_cmd_latch.sv
module dac_cmd_latch
  import dual_dac_if_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int FRAME_W = DATA_W + 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               commit,
  input  logic [FRAME_W-1:0] word,
  output logic [DATA_W-1:0]  code_a,
  output logic [DATA_W-1:0]  code_b,
  output logic               fast_mode,
  output logic               power_down
);
  localparam int SEL_HI = FRAME_W - 1;
  localparam int SPD_B  = FRAME_W - 2;
  localparam int PWR_B  = FRAME_W - 3;
  localparam int SEL_LO = DATA_W;

  tgt_sel_e          sel;
  logic [DATA_W-1:0] data, hold;

  assign sel  = tgt_sel_e'({word[SEL_HI], word[SEL_LO]});
  assign data = word[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      code_a     <= '0;
      code_b     <= '0;
      hold       <= '0;
      fast_mode  <= 1'b0;
      power_down <= 1'b0;
    end else if (commit) begin
      fast_mode  <= word[SPD_B];
      power_down <= word[PWR_B];
      unique case (sel)
        TGT_B_AND_HOLD: begin code_b <= data; hold <= data; end
        TGT_HOLD_ONLY:  hold <= data;
        TGT_A_AND_XFER: begin code_a <= data; code_b <= hold; end
        default: ;
      endcase
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (code_a == '0 && code_b == '0 && !fast_mode && !power_down));

  assert_hold_only_R4: assert property (@(posedge clk) disable iff (rst)
    (commit && sel == TGT_HOLD_ONLY) |=> ($stable(code_a) && $stable(code_b)));

  assert_xfer_R5: assert property (@(posedge clk) disable iff (rst)
    (commit && sel == TGT_A_AND_XFER) |=> (code_b == $past(hold) && code_a == $past(data)));

  assert_reserved_keep_R6: assert property (@(posedge clk) disable iff (rst)
    (commit && sel == TGT_NONE) |=> ($stable(code_a) && $stable(code_b) && $stable(hold)));

  assert_quiet_without_cmd_R7: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(fast_mode) && $stable(power_down) && $stable(code_a) && $stable(code_b)));
endmodule

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if #(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_cs_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b,
  output logic              fast_mode,
  output logic              power_down
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int N_LINES = 3;
  // line order: 0 data, 1 serial clock, 2 select
  localparam logic [N_LINES-1:0] LINE_RST = 3'b110;

  logic [N_LINES-1:0]  raw, synced;
  logic                commit;
  logic [FRAME_W-1:0]  word;

  assign raw = {ser_cs_n, ser_clk, ser_data};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    dac_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(LINE_RST[g])) u_sync (
      .clk(clk), .rst(rst), .d(raw[g]), .q(synced[g])
    );
  end

  dac_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst),
    .cs_n(synced[2]), .sclk(synced[1]), .sdi(synced[0]),
    .commit(commit), .word(word)
  );

  dac_cmd_latch #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_latch (
    .clk(clk), .rst(rst), .commit(commit), .word(word),
    .code_a(code_a), .code_b(code_b),
    .fast_mode(fast_mode), .power_down(power_down)
  );
endmodule

// File: tb/dual_dac_serial_if_bench.sv
`timescale 1ns/1ps
module dual_dac_serial_if_bench;
  localparam int H = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic ser_cs_n = 1'b1, ser_clk = 1'b1, ser_data = 1'b0;
  logic [11:0] code_a, code_b;
  logic fast_mode, power_down;

  int checks = 0, errors = 0;
  logic [11:0] m_a = '0, m_b = '0, m_hold = '0;
  logic m_fast = 1'b0, m_pd = 1'b0;

  always #4 clk = ~clk;

  dual_dac_serial_if u_dual_dac_serial_if (
    .clk(clk), .rst(rst), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .code_a(code_a), .code_b(code_b), .fast_mode(fast_mode), .power_down(power_down)
  );

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [25:0] act, input logic [25:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    @(negedge clk);
    chk(req, {fast_mode, power_down, code_a, code_b}, {m_fast, m_pd, m_a, m_b});
  endtask

  function automatic void apply(input logic [15:0] w);
    m_fast = w[14];
    m_pd   = w[13];
    case ({w[15], w[12]})
      2'b00: begin m_b = w[11:0]; m_hold = w[11:0]; end
      2'b01: m_hold = w[11:0];
      2'b10: begin m_a = w[11:0]; m_b = m_hold; end
      default: ;
    endcase
  endfunction

  task automatic put_bit(input logic b);
    ser_data = b;
    wclk(H);
    ser_clk = 1'b0;
    wclk(H);
    ser_clk = 1'b1;
  endtask

  // send n bits of v MSB first in one select assertion; gap after 8 bits if asked
  task automatic frame(input logic [31:0] v, input int n, input bit gap);
    ser_cs_n = 1'b0;
    wclk(H);
    for (int i = n - 1; i >= 0; i--) begin
      put_bit(v[i]);
      if (gap && i == n - 8) wclk(40);
    end
    wclk(H);
    ser_cs_n = 1'b1;
    wclk(H);
    if (n >= 16) apply(v[n-1 -: 16]);
    else if (n > 0) apply(16'(v & ((32'd1 << n) - 1)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] d;
    logic [15:0] w;
    wclk(5);
    rst = 1'b0;
    wclk(3);
    chk_state("R1 reset state");

    // R2 R3 R4 R5 R6 R7: sweep every select and flag combination
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 4; f++)
        for (int k = 0; k < 3; k++) begin
          d = 12'((s * 1117 + f * 389 + k * 1531 + 90) & 12'hFFF);
          w = {s[1], f[1], f[0], s[0], d};
          frame({16'h0, w}, 16, 1'b0);
          chk_state($sformatf("R2 R3 R4 R5 R6 R7 sel=%0d flags=%0d", s, f));
        end

    // R4 then R5: stage a value, then move both channels together
    frame({16'h0, 16'h0222}, 16, 1'b0);
    chk_state("R3 write B and hold");
    frame({16'h0, 16'h17C3}, 16, 1'b0);
    chk_state("R4 hold only keeps outputs");
    w = 16'h80F5;
    ser_cs_n = 1'b0;
    wclk(H);
    for (int i = 15; i >= 1; i--) put_bit(w[i]);
    ser_data = w[0];
    wclk(H);
    ser_clk = 1'b0;
    wclk(H);
    chk_state("R8 no update at 16th falling edge");
    ser_clk = 1'b1;
    for (int c = 0; c < 2 * H; c++) begin
      @(negedge clk);
      chk("R5 both channels move together", {14'h0, code_a == 12'h0F5, code_b == 12'h7C3},
          {14'h0, code_b == 12'h7C3, code_a == 12'h0F5});
    end
    apply(w);
    chk_state("R8 update before select rises");
    ser_cs_n = 1'b1;
    wclk(H);
    chk_state("R5 final values");

    // R9: split into two 8-bit bursts
    frame({16'h0, 16'h4A5C}, 16, 1'b1);
    chk_state("R9 two bytes form one word");
    frame({16'h0, 16'hC9E1}, 16, 1'b1);
    chk_state("R9 two bytes channel A");

    // R10: early termination commits the partial word right-aligned
    frame(32'h000000A7, 8, 1'b0);
    chk_state("R10 eight-bit partial word");
    frame(32'h00001ABC, 13, 1'b0);
    chk_state("R10 thirteen-bit partial word");

    // R11: select pulse with no bits
    frame(32'h0, 0, 1'b0);
    chk_state("R11 empty select pulse");

    // R12: 20 bits, only the first 16 count
    frame(32'h0008E3DF, 20, 1'b0);
    chk_state("R12 extra bits ignored");
    frame(32'h0006A55F, 20, 1'b0);
    chk_state("R12 extra bits ignored second");

    // R13: activity with select high
    for (int i = 0; i < 16; i++) put_bit(i[0] ^ i[2]);
    wclk(H);
    chk_state("R13 traffic while deselected");

    // R1: reset again after activity
    rst = 1'b1;
    wclk(3);
    rst = 1'b0;
    m_a = '0; m_b = '0; m_hold = '0; m_fast = 1'b0; m_pd = 1'b0;
    wclk(2);
    chk_state("R1 reset after activity");
    frame({16'h0, 16'h8123}, 16, 1'b0);
    chk_state("R1 hold cleared by reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule